// File: doc/BRIEF.md
# Local-Fault Replacement Block Generator

This block stands in for a failed 100G Ethernet client. While its enable input is high, it emits one 66-bit block per clock. Most of these blocks are a fixed local-fault ordered set. At an exact block spacing, it inserts a burst of alignment markers, one per PCS lane. A downstream scrambler and lane distributor consume the stream, so the generated substitute looks like a healthy PCS that is reporting a local fault.

The marker payloads come from a per-lane 64-bit table. The table can be supplied through a parameter, or a built-in per-lane pattern can be selected instead. The number of lanes and the per-lane spacing are parameters. The defaults are 20 lanes and 16383 blocks per lane, which gives 327660 fault blocks between bursts.

Block bit ordering: bits [1:0] hold the sync field, which is transmitted first. Payload octet k occupies bits [9+8k:2+8k]. The block rate equals the clock rate, so the 100 ppm tolerance on the client rate is set by the clock that drives the block.

Top module: `lfr_gen`

## Requirements
- R1: Every block presented with `valid_o` high carries the value 2'b10 in bits [1:0].
- R2: Every valid block with `mark_o` low is the local-fault ordered set. Its fields are:
  - block type 0x4B in bits [9:2];
  - fault code 0x01 in octet 3, bits [33:26];
  - ordered-set code 0x0 in bits [37:34];
  - every other bit zero.
- R3: A burst consists of NUM_LANES markers on consecutive slots, in lane order 0 to NUM_LANES-1. The marker for lane L is {AM_TABLE[64L+63:64L], 2'b10}.
- R4: Between the end of one burst and the start of the next, exactly NUM_LANES*LANE_SPACING fault blocks are emitted. With the default parameters this is 327660.
- R5: `mark_o` is high exactly on the slots that carry alignment markers.
- R6: If `en_i` is low at a clock edge, then after that edge `valid_o` and `mark_o` are low and `block_o` is all zeros.
- R7: The first block after `en_i` rises is the lane 0 marker. A burst begins every time the block is enabled again.
- R8: While `en_i` stays high, `valid_o` is high on every clock, one block per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generation enable |
| block_o | output | 66 | Generated block, sync field in bits [1:0] |
| valid_o | output | 1 | Block on `block_o` is valid |
| mark_o | output | 1 | Block is an alignment marker |

## Verification
The hardest case to reach from the ports is a disable that lands on one particular slot, such as the last marker of a burst or the last fault block before the next burst, followed by a restart. The bench uses a small configuration: 4 lanes and a spacing of 3, so each period is 16 slots. It sweeps the disable point over every slot of more than two periods. After each disable it checks the idle outputs, then re-enables and checks that the stream restarts with the lane 0 marker. Expected blocks are computed in the bench from the slot index modulo the period.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
   localparam int          BLK_W      = 66;
   localparam logic [1:0]  SYNC_CTRL  = 2'b10;
   localparam logic [7:0]  TYPE_OSET  = 8'h4B;
   localparam logic [7:0]  LF_CODE    = 8'h01;
   localparam logic [3:0]  OSET_CODE  = 4'h0;

   function automatic logic [BLK_W-1:0] fault_block();
      logic [BLK_W-1:0] r;
      r        = '0;
      r[1:0]   = SYNC_CTRL;
      r[9:2]   = TYPE_OSET;
      r[33:26] = LF_CODE;
      r[37:34] = OSET_CODE;
      return r;
   endfunction

   // built-in per-lane marker payload, distinct per lane
   function automatic logic [63:0] am_builtin(input int lane);
      logic [7:0] l8;
      l8 = 8'(lane);
      return {l8, 8'hE1, 8'h7C, 8'h2D, ~l8, 8'h1E, 8'h83, 8'hD2};
   endfunction
endpackage

// File: rtl/lfr_slot_seq.sv
module lfr_slot_seq #(
   parameter int NUM_LANES    = 20,
   parameter int LANE_SPACING = 16383,
   localparam int PERIOD      = NUM_LANES * (LANE_SPACING + 1),
   localparam int SLOT_W      = (PERIOD > 1) ? $clog2(PERIOD) : 1,
   localparam int LANE_W      = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   output logic              is_marker_o,
   output logic [LANE_W-1:0] lane_o
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(PERIOD - 1);
   localparam logic [SLOT_W-1:0] NL   = SLOT_W'(NUM_LANES);

   logic [SLOT_W-1:0] slot_q;

   // slot_q is the index of the slot emitted at the next enabled edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (!en_i) begin
         slot_q <= '0;
      end else if (slot_q == LAST) begin
         slot_q <= '0;
      end else begin
         slot_q <= slot_q + 1'b1;
      end
   end

   always_comb begin
      is_marker_o = (slot_q < NL);
      lane_o      = is_marker_o ? LANE_W'(slot_q) : '0;
   end
endmodule

// File: rtl/lfr_block_mux.sv
module lfr_block_mux #(
   parameter int NUM_LANES = 20,
   parameter bit USE_TABLE = 1'b0,
   parameter logic [NUM_LANES*64-1:0] AM_TABLE = '0,
   localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
   input  logic                     is_marker_i,
   input  logic [LANE_W-1:0]        lane_i,
   output logic [lfr_pkg::BLK_W-1:0] block_o
);
   import lfr_pkg::*;

   logic [BLK_W-1:0] am_blk [NUM_LANES];

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      if (USE_TABLE) begin : g_tab
         assign am_blk[l] = {AM_TABLE[l*64 +: 64], SYNC_CTRL};
      end else begin : g_int
         assign am_blk[l] = {am_builtin(l), SYNC_CTRL};
      end
   end

   always_comb begin
      block_o = fault_block();
      if (is_marker_i && (int'(lane_i) < NUM_LANES)) begin
         block_o = am_blk[lane_i];
      end
   end
endmodule

// File: rtl/lfr_gen.sv
module lfr_gen #(
   parameter int NUM_LANES    = 20,
   parameter int LANE_SPACING = 16383,
   parameter bit USE_TABLE    = 1'b0,
   parameter logic [NUM_LANES*64-1:0] AM_TABLE = '0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en_i,
   output logic [65:0] block_o,
   output logic        valid_o,
   output logic        mark_o
);
   localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

   if (NUM_LANES < 1 || NUM_LANES > 256) begin : g_bad_lanes
      $error("lfr_gen: NUM_LANES out of range");
   end
   if (LANE_SPACING < 1) begin : g_bad_spacing
      $error("lfr_gen: LANE_SPACING must be at least 1");
   end
   if (lfr_pkg::BLK_W != 66) begin : g_bad_width
      $error("lfr_gen: block width must be 66");
   end

   logic              is_marker;
   logic [LANE_W-1:0] lane;
   logic [65:0]       blk_next;

   lfr_slot_seq #(
      .NUM_LANES   (NUM_LANES),
      .LANE_SPACING(LANE_SPACING)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_i),
      .is_marker_o(is_marker),
      .lane_o     (lane)
   );

   lfr_block_mux #(
      .NUM_LANES(NUM_LANES),
      .USE_TABLE(USE_TABLE),
      .AM_TABLE (AM_TABLE)
   ) u_mux (
      .is_marker_i(is_marker),
      .lane_i     (lane),
      .block_o    (blk_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         block_o <= '0;
         valid_o <= 1'b0;
         mark_o  <= 1'b0;
      end else if (en_i) begin
         block_o <= blk_next;
         valid_o <= 1'b1;
         mark_o  <= is_marker;
      end else begin
         block_o <= '0;
         valid_o <= 1'b0;
         mark_o  <= 1'b0;
      end
   end
endmodule

// File: rtl/lfr_gen_chk.sv
module lfr_gen_chk #(
   parameter int NUM_LANES    = 20,
   parameter int LANE_SPACING = 16383
) (
   input logic        clk,
   input logic        rst_n,
   input logic        en_i,
   input logic [65:0] block_o,
   input logic        valid_o,
   input logic        mark_o
);
   localparam int GAP = NUM_LANES * LANE_SPACING;
   localparam logic [65:0] FAULT_EXP =
      (66'h01 << 26) | (66'h4B << 2) | 66'h2;

   int data_cnt;
   int burst_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_cnt  <= 0;
         burst_cnt <= 0;
      end else begin
         data_cnt  <= (valid_o && !mark_o) ? data_cnt + 1 : 0;
         burst_cnt <= (valid_o && mark_o) ? burst_cnt + 1 : 0;
      end
   end

   assert_sync_hdr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> block_o[1:0] == 2'b10);

   assert_fault_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !mark_o) |-> block_o == FAULT_EXP);

   assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mark_o) && valid_o) |-> burst_cnt == NUM_LANES);

   assert_gap_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mark_o) && $past(valid_o)) |-> data_cnt == GAP);

   assert_flag_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mark_o |-> valid_o);

   assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!valid_o && !mark_o && block_o == '0));

   assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> mark_o);

   assert_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |=> valid_o);
endmodule

bind lfr_gen lfr_gen_chk #(
   .NUM_LANES   (NUM_LANES),
   .LANE_SPACING(LANE_SPACING)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en_i   (en_i),
   .block_o(block_o),
   .valid_o(valid_o),
   .mark_o (mark_o)
);

// File: tb/lfr_gen_tb.sv
module lfr_gen_tb;
   localparam int NL  = 4;
   localparam int SP  = 3;
   localparam int GAP = NL * SP;
   localparam int PER = NL + GAP;

   function automatic logic [63:0] am_exp(input int l);
      return {8'(8'hA0 + l), 48'h13579BDF2468 ^ 48'(l * 7), 8'h5A};
   endfunction

   function automatic logic [NL*64-1:0] build_tab();
      logic [NL*64-1:0] r;
      for (int l = 0; l < NL; l++) r[l*64 +: 64] = am_exp(l);
      return r;
   endfunction

   localparam logic [NL*64-1:0] TAB = build_tab();

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_i = 1'b0;
   logic [65:0] block_o;
   logic        valid_o;
   logic        mark_o;

   int checks = 0;
   int errors = 0;
   int gap_run = 0;
   bit in_data = 1'b0;

   always #5 clk = ~clk;

   lfr_gen #(
      .NUM_LANES   (NL),
      .LANE_SPACING(SP),
      .USE_TABLE   (1'b1),
      .AM_TABLE    (TAB)
   ) u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_i),
      .block_o(block_o),
      .valid_o(valid_o),
      .mark_o (mark_o)
   );

   function automatic logic [65:0] fault_exp();
      logic [65:0] r;
      r = '0;
      r[1:0] = 2'b10;
      r[9:2] = 8'h4B;
      r[33:26] = 8'h01;
      return r;
   endfunction

   task automatic chk(input string req, input logic [65:0] act,
                      input logic [65:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // slot s of a run: R3/R5/R8 for markers, R2/R5/R8 for fault blocks
   task automatic check_slot(input int k);
      int s;
      s = k % PER;
      chk("R8 valid", 66'(valid_o), 66'd1);
      if (s < NL) begin
         chk("R5 mark", 66'(mark_o), 66'd1);
         chk("R3 marker", block_o, {am_exp(s), 2'b10});
         if (in_data) begin
            chk("R4 gap", 66'(gap_run), 66'(GAP));
         end
         in_data = 1'b0;
         gap_run = 0;
      end else begin
         chk("R5 mark", 66'(mark_o), 66'd0);
         chk("R2 fault", block_o, fault_exp());
         in_data = 1'b1;
         gap_run++;
      end
      chk("R1 sync", 66'(block_o[1:0]), 66'd2);
   endtask

   task automatic run(input int n);
      en_i = 1'b1;
      in_data = 1'b0;
      gap_run = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (k == 0) chk("R7 first marker", block_o, {am_exp(0), 2'b10});
         check_slot(k);
      end
      en_i = 1'b0;
      @(negedge clk);
      chk("R6 idle valid", 66'(valid_o), 66'd0);
      chk("R6 idle mark", 66'(mark_o), 66'd0);
      chk("R6 idle block", block_o, 66'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R6 reset valid", 66'(valid_o), 66'd0);
      chk("R6 reset block", block_o, 66'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 idle after reset", 66'(valid_o), 66'd0);
      // explicit field checks of the fault block (R2)
      en_i = 1'b1;
      repeat (NL + 1) @(negedge clk);
      chk("R2 type", 66'(block_o[9:2]), 66'h4B);
      chk("R2 lane3 code", 66'(block_o[33:26]), 66'h01);
      chk("R2 oset code", 66'(block_o[37:34]), 66'h0);
      chk("R2 other octets", 66'(block_o[65:38]), 66'h0);
      en_i = 1'b0;
      @(negedge clk);
      // long run covering several periods (R4)
      run(4 * PER + 3);
      // disable at every slot of more than two periods (R6, R7)
      for (int s = 1; s <= 2 * PER + 4; s++) begin
         run(s);
         repeat (s % 3) @(negedge clk);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule